// File: doc/BRIEF.md
# NAND Operation Completion Supervisor

This block watches a NAND flash operation through to its end. Once a bus sequencer has placed a program, erase or similar operation on the flash bus, the supervisor waits for a fixed settle interval. It then waits for the synchronized ready/busy line to read high. After that it asks the sequencer for a single read-status command and keeps requesting status byte reads until the device reports ready. The byte that reports ready is decoded into success or a device error. If the device stays not-ready for a configurable number of bytes, the outcome is a timeout instead.

For erase and program operations the caller sets a retry flag. In that mode a failed attempt, whether from a device error or a timeout, makes the supervisor ask the sequencer to start the whole operation again, up to a fixed total number of attempts. The first attempt that succeeds ends the sequence as a success. When every attempt has failed, the sequence ends with a separate give-up code. Each sequence ends with a one-cycle done pulse and a 2-bit result code. Generating the actual bus cycles stays with the sequencer, which is reached through three request/acknowledge style handshakes.

Top module: `nand_op_supervisor`

## Requirements
- R1: While and right after synchronous reset, done_o, launch_req_o, stat_cmd_req_o and stat_rd_req_o are 0 and result_o is 2'b00.
- R2: A go_i pulse while idle raises launch_req_o in the next cycle, and launch_req_o stays high until a cycle in which launch_ack_i is 1.
- R3: After the launch handshake the block waits exactly SETTLE_CYCLES cycles, ignoring rb_i. It then waits for rb_i, seen through a two-flop synchronizer, to be high. If rb_i is already high, stat_cmd_req_o rises SETTLE_CYCLES+1 cycles after the acknowledge edge.
- R4: Each attempt makes exactly one status-command request, held until stat_cmd_ack_i. It then raises stat_rd_req_o and keeps it high across any number of status bytes without another command. At most one request output is high at a time.
- R5: A status byte accepted during polling (stat_vld_i with stat_rd_req_o) that has bit 6 = 1 and bit 0 = 0 ends the sequence with result 2'b00 (ok) in the next cycle.
- R6: Without retry, an accepted byte with bit 6 = 1 and bit 0 = 1 ends the sequence with result 2'b01 (device error).
- R7: An accepted byte with bit 6 = 0 keeps the block polling. The POLL_LIMIT-th consecutive not-ready byte of an attempt is a timeout, reported without retry as 2'b10.
- R8: With retry_en_i = 1 at go, an error or timeout relaunches the operation (a new launch request) while fewer than MAX_TRIES attempts have been made. The first successful attempt ends the sequence with 2'b00.
- R9: With retry enabled, when all MAX_TRIES attempts fail the result is 2'b11 (retries exhausted), whatever the cause of the last failure.
- R10: done_o is high for exactly one cycle per sequence, and result_o changes only in a cycle where done_o is high.
- R11: go_i while a sequence is running, and stat_vld_i while no status read is requested, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start supervising a sequence (taken only while idle) |
| retry_en_i | input | 1 | Sampled with go_i; 1 for erase/program retry mode |
| launch_req_o | output | 1 | Ask the sequencer to (re)issue the operation |
| launch_ack_i | input | 1 | Sequencer has issued the operation |
| rb_i | input | 1 | Asynchronous ready/busy line, high = ready |
| stat_cmd_req_o | output | 1 | Ask the sequencer to issue the read-status command |
| stat_cmd_ack_i | input | 1 | Read-status command issued |
| stat_rd_req_o | output | 1 | Ask the sequencer for status byte reads |
| stat_vld_i | input | 1 | A status byte is on stat_byte_i |
| stat_byte_i | input | 8 | Status byte (bit 6 ready, bit 0 fail) |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_o | output | 2 | 00 ok, 01 device error, 10 timeout, 11 retries exhausted |

## Verification
The hardest situation to reach is a mixed failure path under retry: the first attempt times out or errors and the second behaves differently. The outcome then depends on the attempt counter surviving a full relaunch, settle and ready wait. The bench gets there with a scripted responder that serves status bytes from a queue spanning both attempts, so one queue can give an error then a success, or two full runs of not-ready bytes. The same responder can hold the ready/busy line low for a set time after each launch, and can flood the status inputs with ready bytes outside polling. This shows that neither the settle wait nor the poll is cut short.

// File: rtl/nand_sup_pkg.sv
package nand_sup_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_IO_ERR  = 2'b01,
        RES_TIMEOUT = 2'b10,
        RES_GAVE_UP = 2'b11
    } sup_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SETTLE,
        ST_WAIT_RB,
        ST_STAT_CMD,
        ST_POLL
    } sup_state_e;

    localparam int READY_BIT = 6;
    localparam int FAIL_BIT  = 0;

    typedef struct packed {
        logic ready;
        logic failed;
    } stat_dec_t;

    function automatic stat_dec_t decode_status(input logic [7:0] b);
        stat_dec_t d;
        d.ready  = b[READY_BIT];
        d.failed = b[FAIL_BIT];
        return d;
    endfunction

    // Code reported when a sequence ends on a failed attempt.
    function automatic sup_result_e final_fail_code(input logic retry_mode,
                                                    input sup_result_e cause);
        return retry_mode ? RES_GAVE_UP : cause;
    endfunction

endpackage

// File: rtl/nsp_sync2.sv
module nsp_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], d_i};
    end

    assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/nsp_settle_timer.sv
module nsp_settle_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (load_i)        remain <= CW'(CYCLES - 1);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign expired_o = (remain == '0);
endmodule

// File: rtl/nsp_poll_ctr.sv
module nsp_poll_ctr #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int PW = $clog2(LIMIT + 1);
    logic [PW-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst || clear_i) polls <= '0;
        else if (inc_i)     polls <= polls + 1'b1;
    end

    // The next not-ready byte would be the LIMIT-th one.
    assign last_o = (polls == PW'(LIMIT - 1));
endmodule

// File: rtl/nsp_ctrl.sv
module nsp_ctrl
    import nand_sup_pkg::*;
#(
    parameter int MAX_TRIES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go_i,
    input  logic        retry_en_i,
    input  logic        launch_ack_i,
    input  logic        rb_sync_i,
    input  logic        stat_cmd_ack_i,
    input  logic        stat_vld_i,
    input  logic [7:0]  stat_byte_i,
    input  logic        settle_expired_i,
    input  logic        poll_last_i,
    output logic        settle_load_o,
    output logic        poll_clear_o,
    output logic        poll_inc_o,
    output logic        launch_req_o,
    output logic        stat_cmd_req_o,
    output logic        stat_rd_req_o,
    output logic        done_o,
    output logic [1:0]  result_o
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    sup_state_e  state;
    logic [TW-1:0] tries;
    logic        retry_q;
    sup_result_e res_q;

    stat_dec_t   dec;
    logic        byte_take;
    logic        succeed_now;
    logic        fail_now;
    sup_result_e fail_cause;
    logic        more_tries;

    assign dec        = decode_status(stat_byte_i);
    assign byte_take  = (state == ST_POLL) && stat_vld_i;
    assign more_tries = retry_q && (tries < TW'(MAX_TRIES - 1));

    always_comb begin
        succeed_now = 1'b0;
        fail_now    = 1'b0;
        fail_cause  = RES_IO_ERR;
        if (byte_take) begin
            if (dec.ready) begin
                succeed_now = !dec.failed;
                fail_now    = dec.failed;
                fail_cause  = RES_IO_ERR;
            end else if (poll_last_i) begin
                fail_now    = 1'b1;
                fail_cause  = RES_TIMEOUT;
            end
        end
    end

    assign settle_load_o  = (state == ST_LAUNCH) && launch_ack_i;
    assign poll_clear_o   = (state == ST_STAT_CMD) && stat_cmd_ack_i;
    assign poll_inc_o     = byte_take && !dec.ready;
    assign launch_req_o   = (state == ST_LAUNCH);
    assign stat_cmd_req_o = (state == ST_STAT_CMD);
    assign stat_rd_req_o  = (state == ST_POLL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tries   <= '0;
            retry_q <= 1'b0;
            res_q   <= RES_OK;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go_i) begin
                        tries   <= '0;
                        retry_q <= retry_en_i;
                        state   <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    if (launch_ack_i) state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_expired_i) state <= ST_WAIT_RB;
                end
                ST_WAIT_RB: begin
                    if (rb_sync_i) state <= ST_STAT_CMD;
                end
                ST_STAT_CMD: begin
                    if (stat_cmd_ack_i) state <= ST_POLL;
                end
                ST_POLL: begin
                    if (succeed_now) begin
                        done_o <= 1'b1;
                        res_q  <= RES_OK;
                        state  <= ST_IDLE;
                    end else if (fail_now) begin
                        if (more_tries) begin
                            tries <= tries + 1'b1;
                            state <= ST_LAUNCH;
                        end else begin
                            done_o <= 1'b1;
                            res_q  <= final_fail_code(retry_q, fail_cause);
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result_o = res_q;
endmodule

// File: rtl/nand_op_supervisor.sv
module nand_op_supervisor #(
    parameter int SETTLE_CYCLES = 1000,
    parameter int POLL_LIMIT    = 64,
    parameter int MAX_TRIES     = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       retry_en_i,
    output logic       launch_req_o,
    input  logic       launch_ack_i,
    input  logic       rb_i,
    output logic       stat_cmd_req_o,
    input  logic       stat_cmd_ack_i,
    output logic       stat_rd_req_o,
    input  logic       stat_vld_i,
    input  logic [7:0] stat_byte_i,
    output logic       done_o,
    output logic [1:0] result_o
);
    logic rb_sync;
    logic settle_load, settle_expired;
    logic poll_clear, poll_inc, poll_last;

    nsp_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rb_i),
        .q_o (rb_sync)
    );

    nsp_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .load_i    (settle_load),
        .expired_o (settle_expired)
    );

    nsp_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .clear_i (poll_clear),
        .inc_i   (poll_inc),
        .last_o  (poll_last)
    );

    nsp_ctrl #(.MAX_TRIES(MAX_TRIES)) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .go_i             (go_i),
        .retry_en_i       (retry_en_i),
        .launch_ack_i     (launch_ack_i),
        .rb_sync_i        (rb_sync),
        .stat_cmd_ack_i   (stat_cmd_ack_i),
        .stat_vld_i       (stat_vld_i),
        .stat_byte_i      (stat_byte_i),
        .settle_expired_i (settle_expired),
        .poll_last_i      (poll_last),
        .settle_load_o    (settle_load),
        .poll_clear_o     (poll_clear),
        .poll_inc_o       (poll_inc),
        .launch_req_o     (launch_req_o),
        .stat_cmd_req_o   (stat_cmd_req_o),
        .stat_rd_req_o    (stat_rd_req_o),
        .done_o           (done_o),
        .result_o         (result_o)
    );
endmodule

// File: rtl/nand_sup_chk.sv
module nand_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic       go_i,
    input logic       retry_en_i,
    input logic       launch_req_o,
    input logic       launch_ack_i,
    input logic       rb_i,
    input logic       stat_cmd_req_o,
    input logic       stat_cmd_ack_i,
    input logic       stat_rd_req_o,
    input logic       stat_vld_i,
    input logic [7:0] stat_byte_i,
    input logic       done_o,
    input logic [1:0] result_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!done_o && !launch_req_o && !stat_cmd_req_o && !stat_rd_req_o && result_o == 2'b00));

    // R2
    launch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (launch_req_o && !launch_ack_i) |=> launch_req_o);

    // R3
    cmd_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_cmd_req_o) |-> $past(rb_i, 3));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_cmd_req_o && !stat_cmd_ack_i) |=> stat_cmd_req_o);

    // R4
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({launch_req_o, stat_cmd_req_o, stat_rd_req_o}));

    // R4
    poll_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rd_req_o) |-> $past(stat_cmd_req_o && stat_cmd_ack_i));

    // R5
    ready_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_req_o && stat_vld_i && stat_byte_i[6] && !stat_byte_i[0])
        |=> (done_o && result_o == 2'b00));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);
endmodule

bind nand_op_supervisor nand_sup_chk u_chk (.*);

// File: tb/nand_op_supervisor_bench.sv
module nand_op_supervisor_bench;
    localparam int SETTLE = 20;
    localparam int PLIM   = 6;
    localparam int TRIES  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go_i = 1'b0, retry_en_i = 1'b0;
    logic launch_req_o, launch_ack_i = 1'b0;
    logic rb_i = 1'b1;
    logic stat_cmd_req_o, stat_cmd_ack_i = 1'b0;
    logic stat_rd_req_o, stat_vld_i = 1'b0;
    logic [7:0] stat_byte_i = 8'h00;
    logic done_o;
    logic [1:0] result_o;

    always #5 clk = ~clk;

    nand_op_supervisor #(.SETTLE_CYCLES(SETTLE), .POLL_LIMIT(PLIM), .MAX_TRIES(TRIES))
    u_nand_op_supervisor (.*);

    int vectors = 0, errors = 0;
    int cyc = 0;
    bit started = 0, finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int m_phase = 0, m_settle = 0, m_polls = 0, m_tries = 0;
    bit m_retry = 0, m_s1 = 0, m_s2 = 0, m_done = 0;
    int m_res = 0;

    task automatic m_finish(input int code);
        m_done = 1; m_res = code; m_phase = 0;
    endtask

    task automatic m_fail(input int cause);
        if (m_retry && (m_tries + 1 < TRIES)) begin
            m_tries++; m_phase = 1;
        end else m_finish(m_retry ? 3 : cause);
    endtask

    always @(posedge clk) begin
        cyc++;
        started = 1;
        m_done = 0;
        if (rst) begin
            m_phase = 0; m_res = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            case (m_phase)
                0: if (go_i) begin m_tries = 0; m_retry = retry_en_i; m_phase = 1; end
                1: if (launch_ack_i) begin m_settle = SETTLE; m_phase = 2; end
                2: begin m_settle--; if (m_settle == 0) m_phase = 3; end
                3: if (m_s2) m_phase = 4;
                4: if (stat_cmd_ack_i) begin m_polls = 0; m_phase = 5; end
                5: if (stat_vld_i) begin
                       if (stat_byte_i[6]) begin
                           if (!stat_byte_i[0]) m_finish(0); else m_fail(1);
                       end else begin
                           m_polls++;
                           if (m_polls == PLIM) m_fail(2);
                       end
                   end
                default: m_phase = 0;
            endcase
            m_s2 = m_s1; m_s1 = rb_i;
        end
    end

    // ---------------- per-cycle comparison ----------------
    int dones = 0, last_res = 0, launches = 0, cmds = 0;
    int ack_cyc = 0, cmd_cyc = -1;
    always @(posedge clk) begin
        if (!rst && launch_req_o && launch_ack_i) begin launches++; ack_cyc = cyc; end
        if (!rst && stat_cmd_req_o && stat_cmd_ack_i) cmds++;
    end

    always @(negedge clk) begin
        if (started) begin
            check(done_o == m_done, "R10 done_o", done_o, m_done);
            check(result_o == 2'(m_res), "R5 result_o", result_o, m_res);
            check(launch_req_o == (m_phase == 1), "R2 launch_req_o", launch_req_o, m_phase == 1);
            check(stat_cmd_req_o == (m_phase == 4), "R3 stat_cmd_req_o", stat_cmd_req_o, m_phase == 4);
            check(stat_rd_req_o == (m_phase == 5), "R4 stat_rd_req_o", stat_rd_req_o, m_phase == 5);
            if (done_o) begin dones++; last_res = result_o; end
            if (stat_cmd_req_o && cmd_cyc < 0) cmd_cyc = cyc;
        end
    end

    // ---------------- sequencer / flash responder ----------------
    logic [7:0] bytes_q[$];
    int  rb_busy = 0;
    bit  spurious = 0;
    initial begin
        int lwait = 0, rb_cnt = 0;
        bit prev_ack = 0, tog = 0;
        forever begin
            @(negedge clk);
            if (launch_req_o) begin
                lwait++;
                launch_ack_i = (lwait >= 2);
            end else begin
                lwait = 0;
                launch_ack_i = 1'b0;
            end
            if (prev_ack && !launch_req_o) begin
                rb_cnt = rb_busy;
                rb_i = (rb_busy == 0);
            end else if (rb_cnt > 0) begin
                rb_cnt--;
                if (rb_cnt == 0) rb_i = 1'b1;
            end
            prev_ack = launch_ack_i;
            stat_cmd_ack_i = stat_cmd_req_o;
            if (stat_rd_req_o) begin
                tog = !tog;
                stat_vld_i = tog;
                if (tog) stat_byte_i = (bytes_q.size() > 0) ? bytes_q.pop_front() : 8'h00;
            end else begin
                tog = 0;
                stat_vld_i = spurious;
                stat_byte_i = 8'h40;
            end
        end
    end

    // ---------------- scenarios ----------------
    task automatic run_op(input bit retry, input bit poke, input int exp_res,
                          input int exp_launch, input string req);
        int guard = 0;
        dones = 0; launches = 0; cmds = 0; cmd_cyc = -1;
        @(negedge clk);
        go_i = 1'b1; retry_en_i = retry;
        @(negedge clk);
        go_i = 1'b0; retry_en_i = 1'b0;
        while (dones == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 10) go_i = 1'b1;
            if (poke && guard == 11) go_i = 1'b0;
        end
        repeat (5) @(negedge clk);
        check(dones == 1, {req, " done count"}, dones, 1);
        check(last_res == exp_res, {req, " result"}, last_res, exp_res);
        check(launches == exp_launch, {req, " launches"}, launches, exp_launch);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done_o && !launch_req_o && !stat_cmd_req_o && !stat_rd_req_o, "R1 outputs idle", done_o, 0);
        check(result_o == 2'b00, "R1 result", result_o, 0);
        rst = 1'b0;

        // R5 immediate ready, R3 latency with rb already high
        bytes_q = '{8'h40};
        run_op(0, 0, 0, 1, "R5");
        check(cmd_cyc - ack_cyc == SETTLE + 1, "R3 settle latency", cmd_cyc - ack_cyc, SETTLE + 1);

        // R7/R4 not-ready bytes, rb busy after launch, single command
        rb_busy = 30;
        bytes_q = '{8'h00, 8'h01, 8'h40};
        run_op(0, 0, 0, 1, "R7 poll continue");
        check(cmds == 1, "R4 one status command", cmds, 1);

        // R6 device error
        bytes_q = '{8'h00, 8'h41};
        run_op(0, 0, 1, 1, "R6");

        // R7 timeout
        rb_busy = 0;
        bytes_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run_op(0, 0, 2, 1, "R7 timeout");

        // R8 error then success
        bytes_q = '{8'h41, 8'h00, 8'h40};
        run_op(1, 0, 0, 2, "R8 second try");
        check(cmds == 2, "R4 command per attempt", cmds, 2);

        // R8 first try succeeds
        bytes_q = '{8'hC2};
        run_op(1, 0, 0, 1, "R8 first try");

        // R9 error twice
        bytes_q = '{8'h41, 8'hC1};
        run_op(1, 0, 3, 2, "R9 errors");

        // R9 timeout twice
        bytes_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                    8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80};
        run_op(1, 0, 3, 2, "R9 timeouts");

        // R11 go during run and spurious status bytes ignored
        spurious = 1;
        rb_busy = 12;
        bytes_q = '{8'h00, 8'h41};
        run_op(0, 1, 1, 1, "R11");
        spurious = 0;

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule